// File: doc/BRIEF.md
# ADC conversion sequencer with shadowed readout

This block is the digital controller that sits beside an 8-bit bipolar analog-to-digital converter. Software programs it through a small four-word register port. The port holds a start bit, a mode bit that selects single or continuous operation, a two-bit channel select, a reference select and an interrupt mask. Each conversion is launched on a conversion-rate tick and lasts a fixed number of clock cycles. While a conversion runs, the block holds the sampled channel and reference steady on the converter-facing outputs. It accepts the converter's result on a digital port qualified by a valid strobe.

At the end of each conversion the upper four result bits go straight into the readable high register. The lower four bits go into a shadow register, and the readable low register takes them from the shadow only when software reads the high register. This keeps a high/low pair coherent even if a later conversion completes between the two reads. Every completion sets an interrupt flag. The flag drives the interrupt output unless it is masked, and it stays set until software clears it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Bit 1 of the MODE register (address 0) selects the operating mode: 0 gives continuous conversion and 1 gives single conversion.
- R2: A conversion asserts `conv_busy` for exactly CONV_CYCLES (default 10) consecutive clock cycles. `conv_go` is high only in the first of those cycles.
- R3: In continuous mode, with the start bit (MODE bit 0) at 1, every `tick` that arrives while the block is idle launches a new conversion. The start bit stays at 1 across completions.
- R4: In continuous mode, writing 0 to the start bit during a conversion does not shorten it. The conversion finishes its full length and stores its result, and later ticks launch nothing.
- R5: In single mode, a set start bit launches exactly one conversion on the next idle tick. The hardware clears the start bit when that conversion completes.
- R6: Every completed conversion sets the flag in CFG bit 2 (address 1). `irq` is high when the flag is set and the mask (CFG bit 1) is 0. The mask resets to 1.
- R7: A read of HI (address 2) copies the shadowed low nibble into LO (address 3). A read of LO that is not preceded by a HI read returns the value from the last copy.
- R8: The result is stored without alteration: HI receives result bits 7:4 and the shadow receives bits 3:0. Bit 7 is the sign (1 means at or above virtual ground), and bits 6:0 of a negative result are the ones' complement of its magnitude.
- R9: After reset the channel select (MODE bits 3:2) is 0, which selects the reference input. The reference select (CFG bit 0) is 0, which selects the external reference pin. MODE reads 0 and CFG reads 4'b0010.
- R10: Writing CFG with bit 2 set clears the flag. When that write and a completion fall in the same cycle, the flag stays set.
- R11: The channel and reference selects are sampled when a conversion launches. `conv_chan` and `conv_ref` do not change during a conversion, and a mid-conversion write takes effect from the next conversion.
- R12: No conversion starts without a `tick`. The start bit alone leaves `conv_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Conversion-rate pulse that launches a conversion |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a HI read updates LO) |
| bus_addr | input | 2 | Register address: 0 MODE, 1 CFG, 2 HI, 3 LO |
| bus_wdata | input | DW/2 | Register write data |
| bus_rdata | output | DW/2 | Register read data for `bus_addr`, combinational |
| conv_go | output | 1 | High in the first cycle of a conversion |
| conv_busy | output | 1 | High while a conversion is running |
| conv_chan | output | 2 | Channel sampled at launch |
| conv_ref | output | 1 | Reference select sampled at launch |
| res_valid | input | 1 | Converter result strobe |
| res_data | input | DW | Converter result |
| irq | output | 1 | Unmasked completion interrupt |

## Verification
The hardest case to reach is a flag-clear write that lands in exactly the same clock edge as a completion. The bench counts cycles from the tick pulse that launched a single conversion and schedules the CFG write so it is sampled on the completing edge. A similar count places a start-bit clear part-way through a continuous conversion, so that the remaining busy length can be measured. The coherence of the low half is checked over every possible result value by reading LO both before and after the HI read.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DW          = 8,
  parameter int CONV_CYCLES = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW/2-1:0] bus_wdata,
  output logic [DW/2-1:0] bus_rdata,
  output logic          conv_go,
  output logic          conv_busy,
  output logic [1:0]    conv_chan,
  output logic          conv_ref,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          irq
);
  localparam int BW = DW / 2;
  localparam int CW = $clog2(CONV_CYCLES);
  localparam logic [1:0] A_MODE = 2'd0, A_CFG = 2'd1, A_HI = 2'd2;

  logic          start_q, single_q, ref_q, mask_q, flag_q, busy_q, cref_q;
  logic [1:0]    chan_q, cchan_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] cap_q;
  logic [BW-1:0] hi_q, shd_q, lo_q;

  wire mode_wr = bus_wr && bus_addr == A_MODE;
  wire cfg_wr  = bus_wr && bus_addr == A_CFG;
  wire hi_rd   = bus_rd && bus_addr == A_HI;
  wire launch  = !busy_q && start_q && tick;
  wire last    = busy_q && cnt_q == CW'(CONV_CYCLES - 1);
  wire [DW-1:0] res_now = res_valid ? res_data : cap_q;

  assign conv_busy = busy_q;
  assign conv_go   = busy_q && cnt_q == '0;
  assign conv_chan = cchan_q;
  assign conv_ref  = cref_q;
  assign irq       = flag_q && !mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0; single_q <= 1'b0; chan_q <= 2'd0;
      ref_q <= 1'b0; mask_q <= 1'b1; flag_q <= 1'b0;
    end else begin
      if (mode_wr) begin
        start_q  <= bus_wdata[0];
        single_q <= bus_wdata[1];
        chan_q   <= bus_wdata[3:2];
      end else if (last && single_q) begin
        start_q <= 1'b0;
      end
      if (cfg_wr) begin
        ref_q  <= bus_wdata[0];
        mask_q <= bus_wdata[1];
      end
      if (last) flag_q <= 1'b1;
      else if (cfg_wr && bus_wdata[2]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; cchan_q <= 2'd0; cref_q <= 1'b0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      cchan_q <= chan_q;
      cref_q  <= ref_q;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0; hi_q <= '0; shd_q <= '0; lo_q <= '0;
    end else begin
      if (busy_q && res_valid) cap_q <= res_data;
      if (last) begin
        hi_q  <= res_now[DW-1:BW];
        shd_q <= res_now[BW-1:0];
      end
      if (hi_rd) lo_q <= shd_q;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = BW'({chan_q, single_q, start_q});
      2'd1:    bus_rdata = BW'({busy_q, flag_q, mask_q, ref_q});
      2'd2:    bus_rdata = hi_q;
      default: bus_rdata = lo_q;
    endcase
  end

  // R2
  busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> busy_q);
  // R5
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last && single_q && !mode_wr |=> !start_q);
  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> flag_q);
  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(conv_chan) && $stable(conv_ref));
  // R7
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd |=> $stable(lo_q));
  // R12
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !tick |=> !busy_q);
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [3:0] bus_wdata = 4'd0;
  logic [3:0] bus_rdata;
  logic conv_go, conv_busy, conv_ref, irq, res_valid = 1'b0;
  logic [1:0] conv_chan;
  logic [7:0] res_data = 8'd0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_go(conv_go),
    .conv_busy(conv_busy), .conv_chan(conv_chan), .conv_ref(conv_ref), .res_valid(res_valid),
    .res_data(res_data), .irq(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wait_idle(output int len);
    len = 0;
    while (conv_busy && len < 100) begin len++; @(negedge clk); end
  endtask

  initial begin
    logic [3:0] d, prev_lo;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset values
    rd(0, d); chk("R9 mode reset", d, 0);
    rd(1, d); chk("R9 cfg reset", d, 4'b0010);
    chk("R6 irq reset", irq, 0);

    // R12 start without tick
    res_valid = 1'b1;
    wr(0, 4'b0011);
    repeat (4) @(negedge clk);
    chk("R12 no launch without tick", conv_busy, 0);

    // R5 R7 R8 R2 exhaustive result sweep in single mode
    prev_lo = 4'd0;
    for (int v = 0; v < 256; v++) begin
      res_data = 8'(v);
      if (v != 0) wr(0, 4'b0011);
      pulse_tick();
      chk("R2 go in first cycle", conv_go, 1);
      wait_idle(len);
      chk("R2 conversion length", len, 10);
      rd(0, d); chk("R5 start cleared", d[0], 0);
      rd(3, d); chk("R7 lo holds before hi read", d, prev_lo);
      rd(2, d); chk("R8 hi nibble", d, v >> 4);
      rd(3, d); chk("R8 lo nibble via shadow", d, v & 15);
      prev_lo = 4'(v & 15);
    end
    // R6 masked flag
    rd(1, d); chk("R6 flag set", d[2], 1);
    chk("R6 irq masked", irq, 0);
    wr(1, 4'b0000);
    chk("R6 irq unmasked", irq, 1);
    // R10 clear
    wr(1, 4'b0100);
    chk("R10 flag cleared", irq, 0);
    rd(1, d); chk("R10 cfg after clear", d, 4'b0000);

    // R10 clear in completion cycle
    wr(0, 4'b0011);
    pulse_tick();
    repeat (8) @(negedge clk);
    wr(1, 4'b0100);
    chk("R10 completion wins busy", conv_busy, 0);
    chk("R10 completion wins irq", irq, 1);
    wr(1, 4'b0100);

    // R1 R3 R11 continuous mode
    res_data = 8'hA5;
    wr(1, 4'b0001);
    wr(0, 4'b1001);
    pulse_tick();
    chk("R11 chan sampled", conv_chan, 2);
    chk("R11 ref sampled", conv_ref, 1);
    wr(0, 4'b1101);
    wr(1, 4'b0000);
    chk("R11 chan held", conv_chan, 2);
    chk("R11 ref held", conv_ref, 1);
    wait_idle(len);
    rd(0, d); chk("R1 R3 start kept in continuous", d, 4'b1101);
    rd(2, d); chk("R3 first hi", d, 4'hA);
    res_data = 8'h3C;
    pulse_tick();
    chk("R3 relaunch", conv_busy, 1);
    chk("R11 new chan", conv_chan, 3);
    chk("R11 new ref", conv_ref, 0);
    // R4 stop mid conversion
    wr(0, 4'b1100);
    wait_idle(len);
    chk("R4 conversion completes", len, 8);
    rd(2, d); chk("R4 result stored", d, 4'h3);
    rd(3, d); chk("R4 lo stored", d, 4'hC);
    pulse_tick();
    chk("R4 idle after stop", conv_busy, 0);
    pulse_tick();
    chk("R4 still idle", conv_busy, 0);

    // R8 sign samples
    res_data = 8'h80;
    wr(0, 4'b0011);
    pulse_tick(); wait_idle(len);
    rd(2, d); chk("R8 plus zero hi", d, 4'h8);
    rd(3, d); chk("R8 plus zero lo", d, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule